// File: doc/BRIEF.md
# Power-Down Mode Controller with Clock-Stabilization Wait

This block decides when the clocks of a small processor core may stop. It holds an 8-bit control register that the core reads and writes over a simple register bus. When the core reports that it has executed a sleep instruction, the block enters one of two low-power modes. A select bit in the register picks which one. In sleep mode only the CPU clock stops. In software standby the CPU clock, the peripheral clock and the oscillator all stop, and the register decides whether the pins stay driven.

A wake-up interrupt leaves sleep mode at once. Software standby exits in two steps. The interrupt first restarts the oscillator. The CPU clock then stays off for a programmable number of cycles, 2^(9+N), where N is a 3-bit wait select, so the clock can settle before the core runs again. The register keeps its contents through software standby. It returns to its reset value on system reset and whenever hardware standby is asserted.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (run), every enable output is 1, and reg_rdata_o reads 0x58.
- R2: The register layout is: bit 7 selects standby, bits 6:4 hold the wait select N, bit 3 keeps the pins driven in standby, and bits 2:0 are reserved. Writes to bits 2:0 are ignored and those bits always read 0.
- R3: A register write takes effect only while mode_o is 0 (run). A write in any other mode leaves the register unchanged.
- R4: A cycle with hw_standby_i high loads 0x58 into the register on the next clock edge, and this takes precedence over a write in the same cycle.
- R5: In run mode, with speed_run_i high and bit 7 at 0, a sleep_req_i moves mode_o to 1 (sleep) on the next edge. In sleep, cpu_clk_en_o is 0 and per_clk_en_o, osc_en_o and pin_drv_en_o are 1.
- R6: In run mode, with speed_run_i high and bit 7 at 1, a sleep_req_i moves mode_o to 2 (standby) on the next edge. In standby, cpu_clk_en_o, per_clk_en_o and osc_en_o are 0, and pin_drv_en_o equals bit 3.
- R7: A sleep_req_i while speed_run_i is low leaves the block in run mode.
- R8: In sleep mode, wake_irq_i returns mode_o to 0 on the next edge, with no wait.
- R9: In standby, wake_irq_i moves mode_o to 3 (stabilize) on the next edge. Mode 3 lasts exactly 2^(9+N) cycles with osc_en_o at 1, cpu_clk_en_o and per_clk_en_o at 0, and pin_drv_en_o equal to bit 3. The block then returns to mode 0.
- R10: The register, including bit 7, reads the same value after a standby entry and an interrupt exit as before them.
- R11: wake_irq_i has no effect in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| hw_standby_i | input | 1 | Hardware standby; reloads the register |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sleep_req_i | input | 1 | The core executed a sleep instruction |
| speed_run_i | input | 1 | The core is in high- or medium-speed mode |
| wake_irq_i | input | 1 | Enabled wake-up interrupt |
| mode_o | output | 2 | 0 run, 1 sleep, 2 standby, 3 stabilize |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pin_drv_en_o | output | 1 | Output pin drive enable |

## Verification
The bench measures the stabilization wait at two select values and checks the last stabilize cycle and the first run cycle. An off-by-one counter would return to run one cycle early or late, and a wrong exponent base would miss by a factor of two. It writes to the register while the block sleeps and while it is in hardware standby, and it writes ones to the reserved bits. A design that gates writes wrongly, or stores the reserved bits, would read back the changed value. It also checks the pin drive with the keep bit both set and clear, a sleep request while the core runs slowly, and that the select bit survives an interrupt exit. Getting any of these wrong shows up as a wrong mode or a wrong enable.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STBY  = 2'd2,
    MODE_STAB  = 2'd3
  } pmc_mode_e;

  localparam int          CTRL_W   = 8;
  localparam int          SEL_W    = 3;
  localparam int          RSVD_W   = 3;
  localparam logic [7:0]  CTRL_RST = 8'h58;

  typedef struct packed {
    logic             stby_sel;
    logic [SEL_W-1:0] wait_sel;
    logic             drv_keep;
  } pmc_ctrl_t;
endpackage

// File: rtl/pmc_ctrl_reg.sv
`timescale 1ns/1ps
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_VAL = CTRL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              run_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output pmc_ctrl_t         ctrl_o,
  output logic [CTRL_W-1:0] rdata_o
);
  localparam int STORE_W = CTRL_W - RSVD_W;
  localparam logic [STORE_W-1:0] RST_STORE = RST_VAL[CTRL_W-1:RSVD_W];

  logic [STORE_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ctrl_q <= RST_STORE;
    else if (hw_stby_i)     ctrl_q <= RST_STORE;
    else if (wr_i && run_i) ctrl_q <= wdata_i[CTRL_W-1:RSVD_W];
  end

  assign ctrl_o  = pmc_ctrl_t'(ctrl_q);
  assign rdata_o = {ctrl_q, {RSVD_W{1'b0}}};

  p_hw_stby_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (rdata_o == RST_VAL));

  p_no_write_outside_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hw_stby_i) |=> $stable(rdata_o));
endmodule

// File: rtl/pmc_wait_timer.sv
`timescale 1ns/1ps
module pmc_wait_timer #(
  parameter int BASE_EXP = 9,
  parameter int SEL_W    = 3,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim;
  logic [CNT_W:0]   lim_m1;

  always_comb begin
    lim    = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(sel_i));
    lim_m1 = lim - {{CNT_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= lim_m1[CNT_W-1:0];
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_cnt_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && done_o) |=> done_o);
endmodule

// File: rtl/pmc_mode_fsm.sv
`timescale 1ns/1ps
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_req_i,
  input  logic      speed_run_i,
  input  logic      wake_i,
  input  logic      stby_sel_i,
  input  logic      wait_done_i,
  output pmc_mode_e mode_o,
  output logic      tmr_start_o
);
  pmc_mode_e mode_q, mode_d;

  always_comb begin
    mode_d      = mode_q;
    tmr_start_o = 1'b0;
    unique case (mode_q)
      MODE_RUN:   if (sleep_req_i && speed_run_i)
                    mode_d = stby_sel_i ? MODE_STBY : MODE_SLEEP;
      MODE_SLEEP: if (wake_i) mode_d = MODE_RUN;
      MODE_STBY:  if (wake_i) begin
                    mode_d      = MODE_STAB;
                    tmr_start_o = 1'b1;
                  end
      MODE_STAB:  if (wait_done_i) mode_d = MODE_RUN;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_sleep_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && sleep_req_i && speed_run_i && !stby_sel_i) |=> (mode_q == MODE_SLEEP));

  p_stby_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && sleep_req_i && speed_run_i && stby_sel_i) |=> (mode_q == MODE_STBY));

  p_slow_no_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && !speed_run_i) |=> (mode_q == MODE_RUN));

  p_sleep_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && wake_i) |=> (mode_q == MODE_RUN));

  p_run_wake_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && wake_i && !sleep_req_i) |=> (mode_q == MODE_RUN));
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int BASE_EXP = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_standby_i,
  input  logic              reg_wr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  input  logic              sleep_req_i,
  input  logic              speed_run_i,
  input  logic              wake_irq_i,
  output logic [1:0]        mode_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic              pin_drv_en_o
);
  pmc_ctrl_t ctrl;
  pmc_mode_e mode;
  logic      tmr_start;
  logic      tmr_done;

  pmc_ctrl_reg #(.RST_VAL(CTRL_RST)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_standby_i),
    .run_i     (mode == MODE_RUN),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .ctrl_o    (ctrl),
    .rdata_o   (reg_rdata_o)
  );

  pmc_wait_timer #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .sel_i   (ctrl.wait_sel),
    .done_o  (tmr_done)
  );

  pmc_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .speed_run_i (speed_run_i),
    .wake_i      (wake_irq_i),
    .stby_sel_i  (ctrl.stby_sel),
    .wait_done_i (tmr_done),
    .mode_o      (mode),
    .tmr_start_o (tmr_start)
  );

  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    osc_en_o     = 1'b0;
    pin_drv_en_o = 1'b1;
    unique case (mode)
      MODE_RUN:   begin cpu_clk_en_o = 1'b1; per_clk_en_o = 1'b1; osc_en_o = 1'b1; end
      MODE_SLEEP: begin per_clk_en_o = 1'b1; osc_en_o = 1'b1; end
      MODE_STBY:  pin_drv_en_o = ctrl.drv_keep;
      MODE_STAB:  begin osc_en_o = 1'b1; pin_drv_en_o = ctrl.drv_keep; end
      default:    ;
    endcase
  end

  assign mode_o = mode;

  // the select bit survives an interrupt exit from either low-power mode
  p_sel_kept_on_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_RUN && !hw_standby_i) |=> (ctrl.stby_sel == $past(ctrl.stby_sel)));
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hws = 1'b0, wr = 1'b0, slp = 1'b0, spd = 1'b1, wk = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic [1:0] mode;
  logic       cpu_en, per_en, osc_en, pin_en;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  string      q_rid[$];
  logic [13:0] q_exp[$];

  always #2.5 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_standby_i(hws),
    .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .sleep_req_i(slp), .speed_run_i(spd), .wake_irq_i(wk),
    .mode_o(mode), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_en_o(osc_en), .pin_drv_en_o(pin_en)
  );

  // expected outputs from mode and register value, per R1/R5/R6/R9
  function automatic logic [13:0] mk(input logic [1:0] m, input logic [7:0] r);
    logic c, p, o, d;
    case (m)
      2'd0:    begin c = 1; p = 1; o = 1; d = 1;    end
      2'd1:    begin c = 0; p = 1; o = 1; d = 1;    end
      2'd2:    begin c = 0; p = 0; o = 0; d = r[3]; end
      default: begin c = 0; p = 0; o = 1; d = r[3]; end
    endcase
    return {m, c, p, o, d, r};
  endfunction

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      string       rid;
      logic [13:0] e, got;
      rid = q_rid.pop_front();
      e   = q_exp.pop_front();
      got = {mode, cpu_en, per_en, osc_en, pin_en, rd};
      n_vec++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", rid, got, e);
      end
    end
  end

  task automatic push(input logic [1:0] m, input logic [7:0] r, input string rid);
    q_rid.push_back(rid);
    q_exp.push_back(mk(m, r));
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic s, input logic sp,
                     input logic k, input logic h, input logic [1:0] em,
                     input logic [7:0] er, input string rid);
    @(negedge clk);
    wr = w; wd = d; slp = s; spd = sp; wk = k; hws = h;
    @(posedge clk);
    #1;
    push(em, er, rid);
  endtask

  task automatic idle(input logic [1:0] em, input logic [7:0] er, input string rid);
    cyc(0, 8'h00, 0, 1, 0, 0, em, er, rid);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100us;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    push(2'd0, 8'h58, "R1");

    // R2: reserved bits dropped
    cyc(1, 8'hFF, 0, 1, 0, 0, 2'd0, 8'hF8, "R2");
    cyc(1, 8'h07, 0, 1, 0, 0, 2'd0, 8'h00, "R2");
    cyc(1, 8'h5F, 0, 1, 0, 0, 2'd0, 8'h58, "R2");
    // R11: wake in run
    cyc(0, 8'h00, 0, 1, 1, 0, 2'd0, 8'h58, "R11");
    // R7: sleep request while slow
    cyc(0, 8'h00, 1, 0, 0, 0, 2'd0, 8'h58, "R7");
    idle(2'd0, 8'h58, "R7");
    // R5: enter sleep
    cyc(0, 8'h00, 1, 1, 0, 0, 2'd1, 8'h58, "R5");
    // R3: write blocked in sleep
    cyc(1, 8'hFF, 0, 1, 0, 0, 2'd1, 8'h58, "R3");
    idle(2'd1, 8'h58, "R5");
    // R8: wake from sleep at once
    cyc(0, 8'h00, 0, 1, 1, 0, 2'd0, 8'h58, "R8");

    // standby, N=0, pins kept
    cyc(1, 8'h88, 0, 1, 0, 0, 2'd0, 8'h88, "R2");
    cyc(0, 8'h00, 1, 1, 0, 0, 2'd2, 8'h88, "R6");
    cyc(1, 8'h00, 0, 1, 0, 0, 2'd2, 8'h88, "R3");
    cyc(0, 8'h00, 0, 1, 1, 0, 2'd3, 8'h88, "R9");
    for (int i = 0; i < 511; i++) idle(2'd3, 8'h88, "R9");
    idle(2'd0, 8'h88, "R10");

    // standby, N=1, pins released
    cyc(1, 8'h90, 0, 1, 0, 0, 2'd0, 8'h90, "R2");
    cyc(0, 8'h00, 1, 1, 0, 0, 2'd2, 8'h90, "R6");
    idle(2'd2, 8'h90, "R6");
    cyc(0, 8'h00, 0, 1, 1, 0, 2'd3, 8'h90, "R9");
    cyc(1, 8'hFF, 0, 1, 0, 0, 2'd3, 8'h90, "R3");
    for (int i = 0; i < 1022; i++) idle(2'd3, 8'h90, "R9");
    idle(2'd0, 8'h90, "R10");

    // R4: hardware standby reload
    cyc(1, 8'hF8, 0, 1, 0, 0, 2'd0, 8'hF8, "R2");
    cyc(0, 8'h00, 0, 1, 0, 1, 2'd0, 8'h58, "R4");
    cyc(1, 8'hA8, 0, 1, 0, 0, 2'd0, 8'hA8, "R2");
    cyc(1, 8'hFF, 0, 1, 0, 1, 2'd0, 8'h58, "R4");
    idle(2'd0, 8'h58, "R4");

    @(negedge clk);
    @(negedge clk);
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", q_exp.size());
    end
    summary();
  end
endmodule